// File: doc/BRIEF.md
# Atomic Read-Modify-Write Bus Sequencer

This block sits between a processor core and a shared memory bus and turns one core request into an indivisible read-then-write pair on the bus. It supports three operations. Test-and-set on a byte returns the previous byte and leaves 0xFF in its place. Swap exchanges a 32-bit memory word with a value supplied by the core. Fetch-and-add returns the previous word and stores that word plus an operand.

After accepting a request, the sequencer asks an external arbiter for the bus and waits for the grant. It then raises a lock line for the read access and holds it through the write access. An arbiter that respects the lock cannot hand the bus to another master between the two accesses. Atomic operations from several masters on the same location are therefore serialised and never interleave. Requests that are malformed are answered with an error, and no bus traffic is generated for them.

Top module: `atomic_rmw_seq`

## Requirements
- R1: Operation code 2'b00 (test-and-set) returns the byte at lane `req_addr[1:0]` zero-extended in `rsp_data`. Lane n is bits [8n+7:8n]. The operation writes 0xFF into that byte and leaves the other three bytes of the word unchanged.
- R2: Operation code 2'b01 (swap) returns the old 32-bit word and stores `req_data` in that word.
- R3: Operation code 2'b10 (fetch-and-add) returns the old word and stores the old word plus `req_data`, modulo 2^32.
- R4: Every bus operation is a read access followed by a write access. `bus_lock` rises with the first read cycle and stays high until the write access has completed.
- R5: No read access starts before `bus_gnt` has been seen high. `bus_req` stays high whenever `bus_lock` is high.
- R6: Swap or fetch-and-add with `req_addr[1:0]` not zero, and operation code 2'b11, complete with `rsp_valid` and `rsp_err` both high, and `bus_req` is never raised for them.
- R7: After reset `busy`, `bus_req`, `bus_lock` and `rsp_valid` are low. `busy` is high from the cycle after acceptance through the one-cycle `rsp_valid` pulse and low afterwards. A request presented while `busy` is high is ignored and produces neither a response nor bus traffic.
- R8: Test-and-set drives `bus_be` as the single-lane mask 1 << `req_addr[1:0]`. Swap and fetch-and-add drive 4'hF.
- R9: A low `bus_ready` stretches the current access. Address, direction and lock are held until the access completes.
- R10: When two sequencers run fetch-and-add or test-and-set concurrently on the same word, the results are those of some serial order. In particular, the final word equals the initial value plus the sum of all operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core presents a request this cycle |
| req_op | input | 2 | Operation: 00 test-and-set, 01 swap, 10 fetch-and-add, 11 reserved |
| req_addr | input | ADDR_W | Byte address of the target |
| req_data | input | DATA_W | Swap value or addend |
| busy | output | 1 | Operation in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request refused; qualified by rsp_valid |
| rsp_data | output | DATA_W | Old byte or word; qualified by rsp_valid |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_lock | output | 1 | Holds the bus across the read and write accesses |
| bus_valid | output | 1 | Bus access active |
| bus_we | output | 1 | 1 for a write access, 0 for a read access |
| bus_addr | output | ADDR_W | Word-aligned bus address |
| bus_be | output | DATA_W/8 | Byte-lane enables |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, sampled when bus_ready is high |
| bus_ready | input | 1 | Current access completes this cycle |

## Verification
A sequencer that drops the lock one cycle early, or that starts its read before the grant, lets the second sequencer slip in between the accesses. This appears as a lost update in the shared sum after the concurrent fetch-and-add runs. The effect becomes visible within a few operations when wait states are inserted. A wrong captured read value, lane select or write-back value changes `rsp_data` or the memory word on the very same operation. A state machine that fails to return to idle, or that accepts requests while busy, shows up within one operation as a missing or extra `rsp_valid` pulse, or as a modified memory word that should not have been touched.

// File: rtl/atomic_rmw_seq.sv
module atomic_rmw_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_op,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_data,
  output logic                busy,
  output logic                rsp_valid,
  output logic                rsp_err,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                bus_req,
  input  logic                bus_gnt,
  output logic                bus_lock,
  output logic                bus_valid,
  output logic                bus_we,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W-1:0]   bus_rdata,
  input  logic                bus_ready
);

  localparam int LANES = DATA_W / 8;
  localparam int LB    = $clog2(LANES);
  localparam logic [1:0] OP_TAS  = 2'd0;
  localparam logic [1:0] OP_SWAP = 2'd1;
  localparam logic [1:0] OP_FADD = 2'd2;
  localparam logic [1:0] OP_RSV  = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_READ, S_WRITE, S_DONE} state_t;

  state_t            st;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] opnd_q;
  logic [DATA_W-1:0] old_q;
  logic              err_q;

  wire [LB-1:0] lane    = addr_q[LB-1:0];
  wire          is_byte = (op_q == OP_TAS);
  wire          refuse  = (req_op == OP_RSV) ||
                          ((req_op != OP_TAS) && (req_addr[LB-1:0] != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= OP_TAS;
      addr_q <= '0;
      opnd_q <= '0;
      old_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (req_valid) begin
            op_q   <= req_op;
            addr_q <= req_addr;
            opnd_q <= req_data;
            err_q  <= refuse;
            st     <= refuse ? S_DONE : S_REQ;
          end
        S_REQ:   if (bus_gnt) st <= S_READ;
        S_READ:
          if (bus_ready) begin
            old_q <= bus_rdata;
            st    <= S_WRITE;
          end
        S_WRITE: if (bus_ready) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign bus_lock  = (st == S_READ) || (st == S_WRITE);
  assign bus_req   = (st == S_REQ) || bus_lock;
  assign bus_valid = bus_lock;
  assign bus_we    = (st == S_WRITE);
  assign bus_addr  = {addr_q[ADDR_W-1:LB], {LB{1'b0}}};
  assign bus_be    = is_byte ? (LANES'(1) << lane) : {LANES{1'b1}};
  assign rsp_valid = (st == S_DONE);
  assign rsp_err   = rsp_valid && err_q;

  always_comb begin
    case (op_q)
      OP_TAS:  bus_wdata = {DATA_W{1'b1}};
      OP_SWAP: bus_wdata = opnd_q;
      OP_FADD: bus_wdata = old_q + opnd_q;
      default: bus_wdata = '0;
    endcase
  end

  always_comb begin
    if (err_q)        rsp_data = '0;
    else if (is_byte) rsp_data = {{(DATA_W-8){1'b0}}, old_q[{lane, 3'b000} +: 8]};
    else              rsp_data = old_q;
  end

  a_r4_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock) |-> !bus_we);
  a_r4_release_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_lock) |-> $past(bus_we && bus_ready));
  a_r5_grant_before_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock) |-> $past(bus_gnt));
  a_r5_req_while_locked: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock |-> bus_req);
  a_r6_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !$past(bus_req));
  a_r7_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !busy);
  a_r8_lane_mask: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ($countones(bus_be) == 1 || &bus_be));
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && bus_lock && $stable(bus_we) && $stable(bus_addr)));

endmodule

// File: tb/atomic_rmw_seq_tb.sv
`timescale 1ns/1ps
module atomic_rmw_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]  req_valid = '0;
  logic [1:0]  req_op   [2];
  logic [31:0] req_addr [2];
  logic [31:0] req_data [2];
  logic [1:0]  busy, rsp_valid, rsp_err, bus_req, bus_lock, bus_valid, bus_we, ready;
  logic [31:0] rsp_data [2];
  logic [31:0] bus_addr [2];
  logic [31:0] bus_wdata[2];
  logic [31:0] bus_rdata[2];
  logic [3:0]  bus_be   [2];
  logic [1:0]  gnt = '0;
  logic        last = 1'b0;

  logic [31:0] mem [16];
  logic        init_en = 1'b0;
  logic [3:0]  init_idx = '0;
  logic [31:0] init_val = '0;
  logic        stall_mode = 1'b0;
  logic        ph = 1'b0;
  wire         stall = stall_mode & ph;

  int checks = 0, errors = 0;
  bit done = 0;

  initial for (int m = 0; m < 2; m++) begin
    req_op[m] = '0; req_addr[m] = '0; req_data[m] = '0;
  end

  atomic_rmw_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_op(req_op[0]),
    .req_addr(req_addr[0]), .req_data(req_data[0]), .busy(busy[0]),
    .rsp_valid(rsp_valid[0]), .rsp_err(rsp_err[0]), .rsp_data(rsp_data[0]),
    .bus_req(bus_req[0]), .bus_gnt(gnt[0]), .bus_lock(bus_lock[0]),
    .bus_valid(bus_valid[0]), .bus_we(bus_we[0]), .bus_addr(bus_addr[0]),
    .bus_be(bus_be[0]), .bus_wdata(bus_wdata[0]), .bus_rdata(bus_rdata[0]),
    .bus_ready(ready[0]));

  atomic_rmw_seq u_peer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_op(req_op[1]),
    .req_addr(req_addr[1]), .req_data(req_data[1]), .busy(busy[1]),
    .rsp_valid(rsp_valid[1]), .rsp_err(rsp_err[1]), .rsp_data(rsp_data[1]),
    .bus_req(bus_req[1]), .bus_gnt(gnt[1]), .bus_lock(bus_lock[1]),
    .bus_valid(bus_valid[1]), .bus_we(bus_we[1]), .bus_addr(bus_addr[1]),
    .bus_be(bus_be[1]), .bus_wdata(bus_wdata[1]), .bus_rdata(bus_rdata[1]),
    .bus_ready(ready[1]));

  always_comb for (int m = 0; m < 2; m++) begin
    ready[m]     = gnt[m] & bus_valid[m] & ~stall;
    bus_rdata[m] = mem[bus_addr[m][5:2]];
  end

  always @(posedge clk) begin
    ph <= ~ph;
    if (!rst_n) begin
      gnt <= '0; last <= 1'b0;
    end else if (|(gnt & (bus_req | bus_lock))) begin
      gnt <= gnt;
    end else if (bus_req == 2'b11) begin
      gnt <= last ? 2'b01 : 2'b10; last <= ~last;
    end else begin
      gnt <= bus_req;
      if (bus_req[1]) last <= 1'b1;
      else if (bus_req[0]) last <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (init_en) mem[init_idx] <= init_val;
    for (int m = 0; m < 2; m++)
      if (ready[m] && bus_we[m])
        for (int b = 0; b < 4; b++)
          if (bus_be[m][b]) mem[bus_addr[m][5:2]][8*b +: 8] <= bus_wdata[m][8*b +: 8];
  end

  int v_r4 = 0, v_r5 = 0, v_r10 = 0;
  int breq_cnt [2] = '{0, 0};
  int wait_cnt [2] = '{0, 0};
  int rsp_cnt  [2] = '{0, 0};
  logic [3:0] last_be [2];
  logic [1:0] pl = '0, pwd = '0;

  always @(negedge clk) if (rst_n) begin
    if (bus_valid[0] && bus_valid[1]) v_r10++;
    for (int m = 0; m < 2; m++) begin
      if (bus_lock[m] && !pl[m] && bus_we[m]) v_r4++;
      if (!bus_lock[m] && pl[m] && !pwd[m]) v_r4++;
      if (bus_valid[m] && !gnt[m]) v_r5++;
      if (bus_lock[m] && !bus_req[m]) v_r5++;
      if (bus_req[m]) breq_cnt[m]++;
      if (bus_req[m] && !gnt[m]) wait_cnt[m]++;
      if (rsp_valid[m]) rsp_cnt[m]++;
      if (bus_valid[m] && bus_we[m] && ready[m]) last_be[m] = bus_be[m];
      pl[m]  = bus_lock[m];
      pwd[m] = bus_valid[m] && bus_we[m] && ready[m];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mem(input int idx, input logic [31:0] val);
    @(negedge clk); init_en = 1'b1; init_idx = 4'(idx); init_val = val;
    @(negedge clk); init_en = 1'b0;
  endtask

  task automatic do_op(input int m, input logic [1:0] op, input logic [31:0] addr,
                       input logic [31:0] data, output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid[m] = 1'b1; req_op[m] = op; req_addr[m] = addr; req_data[m] = data;
    @(negedge clk);
    req_valid[m] = 1'b0;
    while (!rsp_valid[m]) @(negedge clk);
    rd = rsp_data[m]; er = rsp_err[m];
    @(negedge clk);
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'h1122_3344 ^ (32'(i) * 32'h9E37_79B9);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, rd1, expw, sum;
    logic er, er1;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk(busy == 0 && bus_req == 0 && bus_lock == 0 && rsp_valid == 0, "R7 reset",
        {24'd0, busy, bus_req, bus_lock, rsp_valid}, 32'd0);
    for (int i = 0; i < 16; i++) set_mem(i, pat(i));

    // R1 / R8: test-and-set, every lane of four words
    for (int w = 0; w < 4; w++) begin
      expw = pat(w);
      for (int l = 0; l < 4; l++) begin
        do_op(0, 2'b00, 32'(w*4 + l), 32'h0, rd, er);
        chk(rd == {24'd0, expw[8*l +: 8]} && !er, "R1 old byte", rd, {24'd0, expw[8*l +: 8]});
        expw[8*l +: 8] = 8'hFF;
        chk(mem[w] == expw, "R1 byte written", mem[w], expw);
        chk(last_be[0] == 4'(1 << l), "R8 lane mask", {28'd0, last_be[0]}, 32'(1 << l));
      end
    end

    // R2 swap sweep
    for (int w = 4; w < 12; w++) begin
      do_op(0, 2'b01, 32'(w*4), ~pat(w), rd, er);
      chk(rd == pat(w) && !er, "R2 old word", rd, pat(w));
      chk(mem[w] == ~pat(w), "R2 stored", mem[w], ~pat(w));
      chk(last_be[0] == 4'hF, "R8 word mask", {28'd0, last_be[0]}, 32'hF);
    end

    // R3 fetch-and-add including wrap
    set_mem(12, 32'hFFFF_FFFE);
    expw = 32'hFFFF_FFFE;
    for (int k = 0; k < 5; k++) begin
      do_op(0, 2'b10, 32'd48, 32'(k*3 + 3), rd, er);
      chk(rd == expw, "R3 old word", rd, expw);
      expw = expw + 32'(k*3 + 3);
      chk(mem[12] == expw, "R3 sum stored", mem[12], expw);
    end

    // R9 wait states
    stall_mode = 1'b1;
    do_op(0, 2'b01, 32'd16, 32'hCAFE_0001, rd, er);
    chk(rd == ~pat(4), "R9 swap under stall", rd, ~pat(4));
    do_op(0, 2'b10, 32'd16, 32'd5, rd, er);
    chk(rd == 32'hCAFE_0001 && mem[4] == 32'hCAFE_0006, "R9 add under stall", mem[4], 32'hCAFE_0006);

    // R7 busy and ignored request
    n0 = rsp_cnt[0];
    expw = mem[13];
    @(negedge clk); req_valid[0] = 1'b1; req_op[0] = 2'b01; req_addr[0] = 32'd20; req_data[0] = 32'h5555_AAAA;
    @(negedge clk); req_valid[0] = 1'b0;
    chk(busy[0] == 1'b1, "R7 busy after accept", {31'd0, busy[0]}, 32'd1);
    req_valid[0] = 1'b1; req_op[0] = 2'b01; req_addr[0] = 32'd52; req_data[0] = 32'hDEAD_BEEF;
    @(negedge clk); req_valid[0] = 1'b0;
    while (!rsp_valid[0]) @(negedge clk);
    chk(busy[0] == 1'b1, "R7 busy with rsp", {31'd0, busy[0]}, 32'd1);
    @(negedge clk);
    chk(busy[0] == 1'b0, "R7 busy low after rsp", {31'd0, busy[0]}, 32'd0);
    repeat (8) @(negedge clk);
    chk(rsp_cnt[0] == n0 + 1, "R7 single response", 32'(rsp_cnt[0] - n0), 32'd1);
    chk(mem[13] == expw, "R7 ignored request untouched", mem[13], expw);
    chk(mem[5] == 32'h5555_AAAA, "R7 accepted request done", mem[5], 32'h5555_AAAA);

    // R6 refused requests
    for (int k = 0; k < 5; k++) begin
      logic [1:0]  op = (k < 3) ? 2'b01 : (k == 3 ? 2'b10 : 2'b11);
      logic [31:0] ad = (k < 3) ? 32'(24 + k + 1) : (k == 3 ? 32'd26 : 32'd24);
      n0 = breq_cnt[0];
      expw = mem[6];
      do_op(0, op, ad, 32'h1234_5678, rd, er);
      chk(er == 1'b1, "R6 error flagged", {31'd0, er}, 32'd1);
      chk(breq_cnt[0] == n0 && mem[6] == expw, "R6 no bus traffic", 32'(breq_cnt[0] - n0), 32'd0);
    end

    // R5 waiting for grant while the peer holds the bus
    n0 = wait_cnt[0];
    set_mem(7, 32'd0); set_mem(8, 32'd0);
    fork
      do_op(1, 2'b10, 32'd28, 32'd9, rd1, er1);
      begin @(negedge clk); do_op(0, 2'b10, 32'd32, 32'd4, rd, er); end
    join
    chk(wait_cnt[0] > n0, "R5 waited for grant", 32'(wait_cnt[0] - n0), 32'd1);
    chk(mem[7] == 32'd9 && mem[8] == 32'd4, "R5 both completed", mem[7] + mem[8], 32'd13);

    // R10 concurrent fetch-and-add, with and without stalls
    for (int pass = 0; pass < 2; pass++) begin
      stall_mode = pass[0];
      set_mem(14, 32'd100);
      sum = 32'd100;
      for (int m = 0; m < 2; m++)
        for (int i = 0; i < 16; i++) sum = sum + 32'(m*1000 + i*7 + 1);
      fork
        for (int i = 0; i < 16; i++) begin
          logic [31:0] r; logic e;
          do_op(0, 2'b10, 32'd56, 32'(i*7 + 1), r, e);
        end
        for (int i = 0; i < 16; i++) begin
          logic [31:0] r; logic e;
          do_op(1, 2'b10, 32'd56, 32'(1000 + i*7 + 1), r, e);
        end
      join
      chk(mem[14] == sum, "R10 concurrent sum", mem[14], sum);
    end

    // R10 concurrent test-and-set: exactly one winner
    set_mem(15, 32'h0000_0000);
    fork
      do_op(0, 2'b00, 32'd62, 32'd0, rd, er);
      do_op(1, 2'b00, 32'd62, 32'd0, rd1, er1);
    join
    chk((rd == 32'h0 && rd1 == 32'hFF) || (rd == 32'hFF && rd1 == 32'h0), "R10 one winner",
        rd ^ rd1, 32'hFF);
    chk(mem[15] == 32'h00FF_0000, "R10 tas word", mem[15], 32'h00FF_0000);

    chk(v_r4 == 0, "R4 lock spans read and write", 32'(v_r4), 32'd0);
    chk(v_r5 == 0, "R5 grant and request rules", 32'(v_r5), 32'd0);
    chk(v_r10 == 0, "R10 no overlapping accesses", 32'(v_r10), 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule